// File: doc/BRIEF.md
# Producer-Tag Register Rename Table

This block tracks, for every architectural register, which in-flight instruction will produce its next value. Each entry names that producer by its sequence tag and carries a flag that says whether the result has already been broadcast. The front end presents one instruction per cycle with up to `NUM_SRC` source registers and at most one destination register. Within the same cycle the block reports, for each source, whether it can be read now or which producer tag it must wait for. It also reports the entry that the destination is about to replace.

When an instruction is accepted, its tag becomes the producer of its destination, and a counter of free physical registers goes down by one. Fetch stops while that counter is zero. Freed registers come back through a separate add port, and the counter never goes above the physical register total. A broadcast result tag marks matching entries as ready. On a squash, the back end supplies its committed copy of the whole table, and that copy replaces every entry at once.

Top module: `rt_rename_table`

## Requirements
- R1: After reset, no register has a producer, so every source lookup reports ready, `free_cnt` equals `NUM_PHYS`, and `ren_ready` is 1.
- R2: A source register whose entry holds a producer with no broadcast result reports `src_ready`=0 and that producer's tag on `src_tag`, in the same cycle. An entry with no producer, or with a broadcast result, reports ready. A disabled source slot reports ready.
- R3: `issuable` is the AND of all source ready flags. An instruction with no enabled sources is therefore issuable.
- R4: `prev_valid`, `prev_ready` and `prev_tag` show the entry currently held by `ren_dst_idx`. After an accepted instruction with a destination, that entry holds the instruction's tag, not ready, from the next cycle.
- R5: Each accepted instruction that has a destination lowers `free_cnt` by one in the next cycle. An instruction without a destination leaves the count unchanged.
- R6: While `free_cnt` is 0, `ren_ready` is 0. A presented instruction is then ignored: the table and the count are unchanged. Once freed registers raise the count above zero, `ren_ready` returns in the following cycle.
- R7: Adding freed registers saturates `free_cnt` at `NUM_PHYS`.
- R8: A broadcast (`wb_valid`, `wb_tag`) sets the ready flag of every entry that holds that tag, from the next cycle. A lookup in the broadcast cycle already reports such a source as ready.
- R9: Source lookups use the table as it was before the same instruction's destination write. A source equal to the destination therefore reports the older producer.
- R10: With `squash` high, `ren_ready` is 0, and the broadcast and any presented instruction are ignored. From the next cycle, entry i holds valid=`restore_valid[i]`, ready=`restore_ready[i]`, tag=`restore_tag[i*8 +: 8]`, and `free_cnt` is unchanged.
- R11: When an install and a broadcast of the entry's old tag hit the same entry in one cycle, the install wins: the entry holds the new tag, not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Instruction presented for renaming |
| ren_ready | output | 1 | Instruction is accepted this cycle |
| ren_tag | input | 8 | Sequence tag of the presented instruction |
| ren_src_en | input | NUM_SRC | Per-slot source enable |
| ren_src_idx | input | NUM_SRC*IDX_W | Source register indices, slot s at [s*IDX_W +: IDX_W] |
| ren_dst_en | input | 1 | Instruction writes a destination |
| ren_dst_idx | input | IDX_W | Destination register index |
| src_ready | output | NUM_SRC | Per-slot source ready |
| src_tag | output | NUM_SRC*8 | Producer tag per slot, slot s at [s*8 +: 8] |
| issuable | output | 1 | All sources ready |
| prev_valid | output | 1 | Destination currently has a producer |
| prev_ready | output | 1 | Ready flag of the replaced producer |
| prev_tag | output | 8 | Tag of the replaced producer |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | 8 | Tag of the broadcast result |
| free_add_valid | input | 1 | Freed registers returned this cycle |
| free_add_num | input | CNT_W | Number of freed registers |
| free_cnt | output | CNT_W | Free physical register count |
| squash | input | 1 | Replace the table with the committed copy |
| restore_valid | input | NUM_ARCH | Committed copy: producer-present flags |
| restore_ready | input | NUM_ARCH | Committed copy: ready flags |
| restore_tag | input | NUM_ARCH*8 | Committed copy: tags, entry i at [i*8 +: 8] |

## Verification
A corrupted entry shows on `src_ready`/`src_tag` in the very cycle an instruction names that register. A destination write to the wrong entry, or a dropped one, shows on the first lookup after acceptance. A lost or misapplied broadcast leaves a source stuck at not ready, which is visible as `issuable` staying low one cycle after the broadcast. A counter off by one shows on `free_cnt` and on `ren_ready` at the boundary of zero or of `NUM_PHYS`, one cycle after the event. A bad squash copy shows on the first lookup of any restored register.

// File: rtl/rt_pkg.sv
package rt_pkg;
    localparam int RT_TAG_W = 8;

    typedef logic [RT_TAG_W-1:0] rt_tag_t;

    typedef struct packed {
        logic    valid;   // an in-flight producer exists
        logic    ready;   // its result has been broadcast
        rt_tag_t tag;     // producer sequence tag
    } rt_entry_t;

    // a source may read now: no producer, result done, or broadcast this cycle
    function automatic logic rt_can_read(rt_entry_t e, logic wb_v, rt_tag_t wb_t);
        return !e.valid || e.ready || (wb_v && (wb_t == e.tag));
    endfunction
endpackage

// File: rtl/rt_table.sv
module rt_table
    import rt_pkg::*;
#(
    parameter int NUM_ARCH = 16,
    parameter int IDX_W    = $clog2(NUM_ARCH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         squash,
    input  logic [NUM_ARCH-1:0]          restore_valid,
    input  logic [NUM_ARCH-1:0]          restore_ready,
    input  logic [NUM_ARCH*RT_TAG_W-1:0] restore_tag,
    input  logic                         wb_valid,
    input  rt_tag_t                      wb_tag,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  rt_tag_t                      wr_tag,
    output rt_entry_t [NUM_ARCH-1:0]     ent_q
);
    typedef struct packed {
        rt_entry_t [NUM_ARCH-1:0] ent;
    } tbl_st_t;

    tbl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_ARCH; i++) begin
            if (squash) begin
                st_d.ent[i].valid = restore_valid[i];
                st_d.ent[i].ready = restore_ready[i];
                st_d.ent[i].tag   = restore_tag[i*RT_TAG_W +: RT_TAG_W];
            end else begin
                if (wb_valid && st_q.ent[i].valid && (st_q.ent[i].tag == wb_tag))
                    st_d.ent[i].ready = 1'b1;
                // an install overrides a same-cycle broadcast
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    st_d.ent[i].valid = 1'b1;
                    st_d.ent[i].ready = 1'b0;
                    st_d.ent[i].tag   = wr_tag;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ent_q = st_q.ent;
endmodule

// File: rtl/rt_src_lookup.sv
module rt_src_lookup
    import rt_pkg::*;
#(
    parameter int NUM_ARCH = 16,
    parameter int IDX_W    = $clog2(NUM_ARCH)
) (
    input  rt_entry_t [NUM_ARCH-1:0] tbl,
    input  logic                     src_en,
    input  logic [IDX_W-1:0]         src_idx,
    input  logic                     wb_valid,
    input  rt_tag_t                  wb_tag,
    output logic                     rdy,
    output rt_tag_t                  tag
);
    rt_entry_t ent;

    always_comb begin
        ent = tbl[src_idx];
        rdy = !src_en || rt_can_read(ent, wb_valid, wb_tag);
        tag = ent.tag;
    end
endmodule

// File: rtl/rt_free_cnt.sv
module rt_free_cnt #(
    parameter int NUM_PHYS = 8,
    parameter int CNT_W    = $clog2(NUM_PHYS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             add_valid,
    input  logic [CNT_W-1:0] add_num,
    output logic [CNT_W-1:0] cnt_q
);
    localparam int SUM_W = CNT_W + 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = SUM_W'(st_q.cnt) + (add_valid ? SUM_W'(add_num) : '0) - SUM_W'(take);
        if (sum > SUM_W'(NUM_PHYS)) st_d.cnt = CNT_W'(NUM_PHYS);
        else                        st_d.cnt = sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= CNT_W'(NUM_PHYS);
        else        st_q     <= st_d;
    end

    assign cnt_q = st_q.cnt;
endmodule

// File: rtl/rt_rename_table.sv
module rt_rename_table
    import rt_pkg::*;
#(
    parameter int NUM_ARCH = 16,
    parameter int NUM_SRC  = 2,
    parameter int NUM_PHYS = 8,
    parameter int IDX_W    = $clog2(NUM_ARCH),
    parameter int CNT_W    = $clog2(NUM_PHYS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ren_valid,
    output logic                         ren_ready,
    input  logic [RT_TAG_W-1:0]          ren_tag,
    input  logic [NUM_SRC-1:0]           ren_src_en,
    input  logic [NUM_SRC*IDX_W-1:0]     ren_src_idx,
    input  logic                         ren_dst_en,
    input  logic [IDX_W-1:0]             ren_dst_idx,
    output logic [NUM_SRC-1:0]           src_ready,
    output logic [NUM_SRC*RT_TAG_W-1:0]  src_tag,
    output logic                         issuable,
    output logic                         prev_valid,
    output logic                         prev_ready,
    output logic [RT_TAG_W-1:0]          prev_tag,
    input  logic                         wb_valid,
    input  logic [RT_TAG_W-1:0]          wb_tag,
    input  logic                         free_add_valid,
    input  logic [CNT_W-1:0]             free_add_num,
    output logic [CNT_W-1:0]             free_cnt,
    input  logic                         squash,
    input  logic [NUM_ARCH-1:0]          restore_valid,
    input  logic [NUM_ARCH-1:0]          restore_ready,
    input  logic [NUM_ARCH*RT_TAG_W-1:0] restore_tag
);
    rt_entry_t [NUM_ARCH-1:0] tbl_q;
    rt_entry_t                dst_ent;
    logic                     accept;
    logic                     install;

    assign ren_ready = !squash && (free_cnt != '0);
    assign accept    = ren_valid && ren_ready;
    assign install   = accept && ren_dst_en;

    rt_table #(.NUM_ARCH(NUM_ARCH), .IDX_W(IDX_W)) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .squash        (squash),
        .restore_valid (restore_valid),
        .restore_ready (restore_ready),
        .restore_tag   (restore_tag),
        .wb_valid      (wb_valid),
        .wb_tag        (wb_tag),
        .wr_en         (install),
        .wr_idx        (ren_dst_idx),
        .wr_tag        (ren_tag),
        .ent_q         (tbl_q)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rt_src_lookup #(.NUM_ARCH(NUM_ARCH), .IDX_W(IDX_W)) u_lookup (
            .tbl      (tbl_q),
            .src_en   (ren_src_en[s]),
            .src_idx  (ren_src_idx[s*IDX_W +: IDX_W]),
            .wb_valid (wb_valid),
            .wb_tag   (wb_tag),
            .rdy      (src_ready[s]),
            .tag      (src_tag[s*RT_TAG_W +: RT_TAG_W])
        );
    end

    assign issuable   = &src_ready;
    assign dst_ent    = tbl_q[ren_dst_idx];
    assign prev_valid = dst_ent.valid;
    assign prev_ready = dst_ent.ready;
    assign prev_tag   = dst_ent.tag;

    rt_free_cnt #(.NUM_PHYS(NUM_PHYS), .CNT_W(CNT_W)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (install),
        .add_valid (free_add_valid),
        .add_num   (free_add_num),
        .cnt_q     (free_cnt)
    );
endmodule

// File: rtl/rt_rename_checker.sv
module rt_rename_checker #(
    parameter int NUM_SRC  = 2,
    parameter int NUM_PHYS = 8,
    parameter int IDX_W    = 4,
    parameter int CNT_W    = 4,
    parameter int TAG_W    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ren_valid,
    input logic               ren_ready,
    input logic [TAG_W-1:0]   ren_tag,
    input logic [NUM_SRC-1:0] ren_src_en,
    input logic [IDX_W-1:0]   src0_idx,
    input logic               src0_ready,
    input logic [TAG_W-1:0]   src0_tag,
    input logic               ren_dst_en,
    input logic [IDX_W-1:0]   ren_dst_idx,
    input logic               issuable,
    input logic               wb_valid,
    input logic [TAG_W-1:0]   wb_tag,
    input logic               free_add_valid,
    input logic [CNT_W-1:0]   free_cnt,
    input logic               squash
);
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CNT_W'(NUM_PHYS));

    a_r6_stall_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt == '0) |-> !ren_ready);

    a_r6_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt == '0 && !free_add_valid) |=> (free_cnt == '0));

    a_r5_take_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && ren_dst_en && !free_add_valid)
        |=> (free_cnt == $past(free_cnt) - 1'b1));

    a_r3_no_src_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_src_en == '0) |-> issuable);

    a_r10_squash_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> !ren_ready);

    a_r4_install_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && ren_dst_en)
        |=> (!(ren_src_en[0] && !squash && (src0_idx == $past(ren_dst_idx))
               && !(wb_valid && wb_tag == $past(ren_tag)))
             || (!src0_ready && src0_tag == $past(ren_tag))));
endmodule

bind rt_rename_table rt_rename_checker #(
    .NUM_SRC  (NUM_SRC),
    .NUM_PHYS (NUM_PHYS),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W),
    .TAG_W    (rt_pkg::RT_TAG_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ren_valid      (ren_valid),
    .ren_ready      (ren_ready),
    .ren_tag        (ren_tag),
    .ren_src_en     (ren_src_en),
    .src0_idx       (ren_src_idx[IDX_W-1:0]),
    .src0_ready     (src_ready[0]),
    .src0_tag       (src_tag[rt_pkg::RT_TAG_W-1:0]),
    .ren_dst_en     (ren_dst_en),
    .ren_dst_idx    (ren_dst_idx),
    .issuable       (issuable),
    .wb_valid       (wb_valid),
    .wb_tag         (wb_tag),
    .free_add_valid (free_add_valid),
    .free_cnt       (free_cnt),
    .squash         (squash)
);

// File: tb/tb_rt_rename_table.sv
module tb_rt_rename_table;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_ARCH   = 16;
    localparam int NUM_SRC    = 2;
    localparam int NUM_PHYS   = 8;
    localparam int IDX_W      = 4;
    localparam int CNT_W      = 4;
    localparam int TW         = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ren_valid, ren_ready, ren_dst_en, issuable;
    logic prev_valid, prev_ready, wb_valid, free_add_valid, squash;
    logic [TW-1:0] ren_tag, prev_tag, wb_tag;
    logic [NUM_SRC-1:0] ren_src_en, src_ready;
    logic [NUM_SRC*IDX_W-1:0] ren_src_idx;
    logic [IDX_W-1:0] ren_dst_idx;
    logic [NUM_SRC*TW-1:0] src_tag;
    logic [CNT_W-1:0] free_add_num, free_cnt;
    logic [NUM_ARCH-1:0] restore_valid, restore_ready;
    logic [NUM_ARCH*TW-1:0] restore_tag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt_rename_table #(.NUM_ARCH(NUM_ARCH), .NUM_SRC(NUM_SRC), .NUM_PHYS(NUM_PHYS)) dut (.*);

    typedef struct packed {
        logic          d_en;  logic [3:0] d_idx; logic [7:0] tag;
        logic          s0_en; logic [3:0] s0;    logic s1_en; logic [3:0] s1;
        logic          e_r0;  logic [7:0] e_t0;  logic e_r1;  logic [7:0] e_t1;
        logic          e_iss; logic e_pv;        logic [7:0] e_pt;
    } vec_t;

    // R2 R3 R4 R9: install chain with lookups, no broadcasts
    localparam vec_t VEC [4] = '{
        '{1'b1, 4'd1, 8'd10, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 8'd0,  1'b1, 8'd0,  1'b1, 1'b0, 8'd0},
        '{1'b1, 4'd2, 8'd11, 1'b1, 4'd1, 1'b1, 4'd3, 1'b0, 8'd10, 1'b1, 8'd0,  1'b0, 1'b0, 8'd0},
        '{1'b1, 4'd1, 8'd12, 1'b1, 4'd1, 1'b1, 4'd2, 1'b0, 8'd10, 1'b0, 8'd11, 1'b0, 1'b1, 8'd10},
        '{1'b0, 4'd0, 8'd13, 1'b1, 4'd1, 1'b0, 4'd0, 1'b0, 8'd12, 1'b1, 8'd0,  1'b0, 1'b0, 8'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        ren_valid = 0; ren_tag = 0; ren_src_en = 0; ren_src_idx = 0;
        ren_dst_en = 0; ren_dst_idx = 0; wb_valid = 0; wb_tag = 0;
        free_add_valid = 0; free_add_num = 0; squash = 0;
        restore_valid = 0; restore_ready = 0; restore_tag = 0;
    endtask

    // look at one register through source slot 0 without renaming
    task automatic peek(input int idx, input string req, input int e_rdy, input int e_tag);
        @(negedge clk);
        ren_src_en = 2'b01; ren_src_idx[3:0] = 4'(idx);
        #1;
        check(req, int'(src_ready[0]), e_rdy);
        if (e_rdy == 0) check(req, int'(src_tag[7:0]), e_tag);
        idle();
    endtask

    task automatic rename(input int dst, input int tag);
        @(negedge clk);
        ren_valid = 1; ren_dst_en = 1; ren_dst_idx = 4'(dst); ren_tag = 8'(tag);
        @(posedge clk); #1;
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        #1;
        check("R1 free_cnt", int'(free_cnt), NUM_PHYS);
        check("R1 ren_ready", int'(ren_ready), 1);
        peek(5, "R1 lookup", 1, 0);

        // vector walk
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ren_valid = 1; ren_dst_en = VEC[k].d_en; ren_dst_idx = VEC[k].d_idx;
            ren_tag = VEC[k].tag; ren_src_en = {VEC[k].s1_en, VEC[k].s0_en};
            ren_src_idx = {VEC[k].s1, VEC[k].s0};
            #1;
            check("R2 src0 ready", int'(src_ready[0]), int'(VEC[k].e_r0));
            if (!VEC[k].e_r0) check("R2 R9 src0 tag", int'(src_tag[7:0]), int'(VEC[k].e_t0));
            check("R2 src1 ready", int'(src_ready[1]), int'(VEC[k].e_r1));
            if (!VEC[k].e_r1) check("R2 src1 tag", int'(src_tag[15:8]), int'(VEC[k].e_t1));
            check("R3 issuable", int'(issuable), int'(VEC[k].e_iss));
            if (VEC[k].d_en) begin
                check("R4 prev_valid", int'(prev_valid), int'(VEC[k].e_pv));
                if (VEC[k].e_pv) check("R4 prev_tag", int'(prev_tag), int'(VEC[k].e_pt));
            end
            @(posedge clk); #1;
            idle();
        end
        check("R5 free after three installs", int'(free_cnt), 5);
        peek(1, "R4 installed", 0, 12);

        // R8 broadcast bypass in the same cycle, then stored
        @(negedge clk);
        wb_valid = 1; wb_tag = 8'd11; ren_src_en = 2'b01; ren_src_idx[3:0] = 4'd2;
        #1;
        check("R8 bypass ready", int'(src_ready[0]), 1);
        @(posedge clk); #1; idle();
        peek(2, "R8 stored ready", 1, 0);

        // R11 install beats broadcast of the old tag
        @(negedge clk);
        ren_valid = 1; ren_dst_en = 1; ren_dst_idx = 4'd1; ren_tag = 8'd20;
        wb_valid = 1; wb_tag = 8'd12;
        @(posedge clk); #1; idle();
        peek(1, "R11 install wins", 0, 20);
        check("R5 free", int'(free_cnt), 4);

        // R6 exhaust the pool
        rename(3, 21); rename(4, 22); rename(5, 23); rename(6, 24);
        check("R6 free zero", int'(free_cnt), 0);
        check("R6 ren_ready low", int'(ren_ready), 0);
        rename(4, 30);
        peek(4, "R6 ignored install", 0, 22);
        check("R6 count held", int'(free_cnt), 0);

        // R6 release after freeing
        @(negedge clk);
        free_add_valid = 1; free_add_num = 4'd3;
        @(posedge clk); #1; idle();
        check("R6 released count", int'(free_cnt), 3);
        check("R6 released ready", int'(ren_ready), 1);

        // R7 saturate
        @(negedge clk);
        free_add_valid = 1; free_add_num = 4'd15;
        @(posedge clk); #1; idle();
        check("R7 saturated", int'(free_cnt), NUM_PHYS);

        // R10 squash restore
        @(negedge clk);
        squash = 1;
        restore_valid[7] = 1; restore_tag[7*TW +: TW] = 8'd40;
        restore_valid[1] = 1; restore_ready[1] = 1; restore_tag[1*TW +: TW] = 8'd41;
        ren_valid = 1; ren_dst_en = 1; ren_dst_idx = 4'd9; ren_tag = 8'd50;
        wb_valid = 1; wb_tag = 8'd40;
        #1;
        check("R10 ren_ready low", int'(ren_ready), 0);
        @(posedge clk); #1; idle();
        peek(7, "R10 restored pending", 0, 40);
        peek(1, "R10 restored ready", 1, 0);
        peek(3, "R10 cleared entry", 1, 0);
        peek(9, "R10 install ignored", 1, 0);
        check("R10 free unchanged", int'(free_cnt), NUM_PHYS);

        // R3 both sources ready
        @(negedge clk);
        ren_src_en = 2'b11; ren_src_idx = {4'd3, 4'd1};
        #1;
        check("R3 all ready issuable", int'(issuable), 1);
        ren_src_idx = {4'd7, 4'd1};
        #1;
        check("R3 one pending", int'(issuable), 0);
        idle();

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule